// File: doc/BRIEF.md
# Four-Channel DC Offset Calibration Controller

This block is the digital control for four ground-referenced output channels. Each channel has a trim DAC that cancels its DC offset. A correction for a channel is set in one of two ways. The first is a measured run: a successive-approximation search that, bit by bit, asks an offset comparator whether the trial correction overshoots the channel's real offset. The second is a direct load, which copies a stored correction word into the channel without measuring. The measured run is much slower than the direct load. Each mode has its own completion flag per channel, and a combined flag reports that either mode has finished.

A single shared engine does the work. Trigger bits are one-cycle pulses that register-write logic raises. Each accepted trigger becomes a pending request, and the engine serves pending requests one at a time, always taking the lowest-numbered channel first. Once a correction is in place it stays on the channel's output word until the channel is triggered again or disabled. Dropping a channel's enable aborts any work on that channel, zeroes its correction and clears its flags.

All pins are plain control and status levels or pulses. There is no streaming data path, so no valid/ready handshake is used. The comparator input is read only in the single cycle at the end of each settling window, so no back-pressure applies to it either.

Top module: `dcoc_ctrl`

## Requirements
- R1: After reset every correction word is 0 and every meas_done, load_done and cal_done bit is 0.
- R2: While chan_en[i] is 0, trig_meas[i] and trig_load[i] are ignored: correction word i stays 0 and the channel's flags stay 0.
- R3: A measured run on channel i is an MSB-first successive-approximation search over a CW-bit two's-complement word that starts from trial 0. cmp_above[i]=1 means the current trial exceeds the channel's offset, and the bit under trial is then cleared. Each trial is held SETTLE_CYC cycles and the comparator is sampled in the last of them. The final word equals the offset for any offset in [-2^(CW-1), 2^(CW-1)-1]. During the run, corr_word for the channel shows the trial word.
- R4: With the engine idle, meas_done[i] rises 1+CW*SETTLE_CYC clock edges after the edge that captured trig_meas[i].
- R5: A direct load on channel i copies store_word slice i (bits i*CW +: CW) into correction word i. load_done[i] rises 1+LOAD_CYC edges after the edge that captured the trigger, with the engine idle.
- R6: cal_done[i] equals meas_done[i] OR load_done[i]. The two mode flags are never set together.
- R7: An accepted trigger on channel i clears meas_done[i] and load_done[i] at the capturing edge. Other channels' flags are untouched.
- R8: A correction word holds its value until the next operation on the channel completes. Later changes of store_word or cmp_above do not move it.
- R9: Pending requests are served one at a time in ascending channel order: triggers raised together on channels 3, 1 and 0 complete in the order 0, 1, 3.
- R10: Clearing chan_en[i] while channel i is being served aborts the operation, zeroes the word and clears the flags. The next pending channel is then served.
- R11: A trigger on the channel the engine is serving, or on the channel it is granting in that cycle, is ignored.
- R12: If trig_meas[i] and trig_load[i] arrive in the same cycle, the measured run is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NCH | Per-channel enable |
| trig_meas | input | NCH | Per-channel measured-run trigger pulse |
| trig_load | input | NCH | Per-channel direct-load trigger pulse |
| cmp_above | input | NCH | Comparator: trial correction exceeds offset |
| store_word | input | NCH*CW | Stored correction words, channel i at i*CW |
| corr_word | output | NCH*CW | Correction words to the trim DACs, channel i at i*CW |
| meas_done | output | NCH | Measured run complete |
| load_done | output | NCH | Direct load complete |
| cal_done | output | NCH | Either mode complete |

## Verification
A table of vectors runs measured searches against comparator offsets at both extremes of the signed range, at zero, at -1 and at mid-range values. Together these tell a correct MSB-first search, including its sign-bit handling, apart from off-by-one-bit or unsigned searches. The same table runs direct loads of words with the sign bit set and clear. Comparing the exact completion latency of both modes separates the two paths and catches settle-count errors. Directed cases then cover simultaneous triggers (service order), disable in mid-run (abort and hand-over), triggers on a busy channel or a disabled channel, both triggers together, and holding of the word after the stored value changes.

// File: rtl/dcoc_pkg.sv
package dcoc_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_MEAS = 2'd1,
    ENG_LOAD = 2'd2
  } eng_state_e;
endpackage

// File: rtl/dcoc_trig_queue.sv
module dcoc_trig_queue #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] trig_meas,
  input  logic [NCH-1:0] trig_load,
  input  logic [NCH-1:0] busy_oh,
  input  logic [NCH-1:0] take_oh,
  output logic [NCH-1:0] pend_meas,
  output logic [NCH-1:0] pend_load,
  output logic [NCH-1:0] accept
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign accept[i] = chan_en[i] & (trig_meas[i] | trig_load[i]) & ~busy_oh[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_meas[i] <= 1'b0;
        pend_load[i] <= 1'b0;
      end else if (!chan_en[i]) begin
        pend_meas[i] <= 1'b0;
        pend_load[i] <= 1'b0;
      end else if (accept[i]) begin
        pend_meas[i] <= trig_meas[i];
        pend_load[i] <= ~trig_meas[i];
      end else if (take_oh[i]) begin
        pend_meas[i] <= 1'b0;
        pend_load[i] <= 1'b0;
      end
    end

    // R12: a channel never holds both request kinds
    a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
      !(pend_meas[i] && pend_load[i]));
    // R2: a disabled channel keeps no request
    a_r2_dis_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[i] |=> !(pend_meas[i] || pend_load[i]));
  end
endmodule

// File: rtl/dcoc_arbiter.sv
module dcoc_arbiter #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  output logic           req_valid,
  output logic [IW-1:0]  req_idx
);
  always_comb begin
    req_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i]) req_idx = IW'(i);
    end
  end
  assign req_valid = |req;

  // R9: the chosen channel has no lower-numbered requester
  a_r9_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req[req_idx] && ((req & ((NCH'(1) << req_idx) - NCH'(1))) == '0)));
endmodule

// File: rtl/dcoc_engine.sv
module dcoc_engine
  import dcoc_pkg::*;
#(
  parameter int NCH        = 4,
  parameter int CW         = 8,
  parameter int SETTLE_CYC = 16,
  parameter int LOAD_CYC   = 8,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW   = (CW > 1) ? $clog2(CW) : 1,
  localparam int CMAX = (SETTLE_CYC > LOAD_CYC) ? SETTLE_CYC : LOAD_CYC,
  localparam int CNTW = $clog2(CMAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_en,
  input  logic              req_valid,
  input  logic [IW-1:0]     req_idx,
  input  logic [NCH-1:0]    pend_meas,
  input  logic [NCH-1:0]    cmp_above,
  input  logic [NCH*CW-1:0] store_word,
  output logic [NCH-1:0]    busy_oh,
  output logic [NCH-1:0]    take_oh,
  output logic              trial_act,
  output logic [IW-1:0]     trial_ch,
  output logic [CW-1:0]     trial_val,
  output logic [NCH-1:0]    wr_oh,
  output logic              wr_meas,
  output logic [CW-1:0]     wr_val
);
  localparam logic [CW-1:0] MSB = CW'(1) << (CW - 1);

  eng_state_e       state;
  logic [IW-1:0]    ch;
  logic [CW-1:0]    sar_u;   // offset-binary trial
  logic [BW-1:0]    bit_idx;
  logic [CNTW-1:0]  cnt;

  logic             grant;
  logic             aborting;
  logic             window_end;
  logic [CW-1:0]    bit_mask;
  logic [CW-1:0]    sar_dec;

  assign grant      = (state == ENG_IDLE) && req_valid;
  assign aborting   = (state != ENG_IDLE) && !chan_en[ch];
  assign window_end = (state == ENG_MEAS) ? (cnt == CNTW'(SETTLE_CYC - 1))
                                          : (cnt == CNTW'(LOAD_CYC - 1));
  assign bit_mask   = CW'(1) << bit_idx;
  assign sar_dec    = cmp_above[ch] ? (sar_u & ~bit_mask) : sar_u;

  always_comb begin
    take_oh = '0;
    busy_oh = '0;
    if (grant) begin
      take_oh[req_idx] = 1'b1;
      busy_oh[req_idx] = 1'b1;
    end else if (state != ENG_IDLE) begin
      busy_oh[ch] = 1'b1;
    end
  end

  assign trial_act = (state == ENG_MEAS);
  assign trial_ch  = ch;
  assign trial_val = sar_u ^ MSB;

  always_comb begin
    wr_oh   = '0;
    wr_meas = 1'b0;
    wr_val  = '0;
    if (!aborting && window_end) begin
      if (state == ENG_MEAS && bit_idx == '0) begin
        wr_oh[ch] = 1'b1;
        wr_meas   = 1'b1;
        wr_val    = sar_dec ^ MSB;
      end else if (state == ENG_LOAD) begin
        wr_oh[ch] = 1'b1;
        wr_val    = store_word[ch*CW +: CW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ENG_IDLE;
      ch      <= '0;
      sar_u   <= '0;
      bit_idx <= '0;
      cnt     <= '0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (grant) begin
            ch      <= req_idx;
            cnt     <= '0;
            sar_u   <= MSB;
            bit_idx <= BW'(CW - 1);
            state   <= pend_meas[req_idx] ? ENG_MEAS : ENG_LOAD;
          end
        end
        ENG_MEAS: begin
          if (aborting) begin
            state <= ENG_IDLE;
          end else if (window_end) begin
            cnt <= '0;
            if (bit_idx == '0) begin
              sar_u <= sar_dec;
              state <= ENG_IDLE;
            end else begin
              sar_u   <= sar_dec | (bit_mask >> 1);
              bit_idx <= bit_idx - BW'(1);
            end
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        ENG_LOAD: begin
          if (aborting || window_end) begin
            state <= ENG_IDLE;
          end else begin
            cnt <= cnt + CNTW'(1);
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R3: the settle counter never passes its window
  a_r3_settle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_MEAS) |-> (cnt < CNTW'(SETTLE_CYC)));
  // R10: losing the served channel's enable returns the engine to idle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state != ENG_IDLE) && !chan_en[ch]) |=> (state == ENG_IDLE));
  // R11: exactly one channel is marked busy while an operation runs
  a_r11_busy_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ENG_IDLE) |-> $onehot(busy_oh));
  // R9: at most one completion write per cycle
  a_r9_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_oh));
endmodule

// File: rtl/dcoc_chan_bank.sv
module dcoc_chan_bank #(
  parameter int NCH = 4,
  parameter int CW  = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    accept,
  input  logic [NCH-1:0]    wr_oh,
  input  logic              wr_meas,
  input  logic [CW-1:0]     wr_val,
  input  logic              trial_act,
  input  logic [IW-1:0]     trial_ch,
  input  logic [CW-1:0]     trial_val,
  output logic [NCH*CW-1:0] corr_word,
  output logic [NCH-1:0]    meas_done,
  output logic [NCH-1:0]    load_done,
  output logic [NCH-1:0]    cal_done
);
  logic [CW-1:0] held [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        held[i]      <= '0;
        meas_done[i] <= 1'b0;
        load_done[i] <= 1'b0;
      end else if (!chan_en[i]) begin
        held[i]      <= '0;
        meas_done[i] <= 1'b0;
        load_done[i] <= 1'b0;
      end else if (wr_oh[i]) begin
        held[i]      <= wr_val;
        meas_done[i] <= wr_meas;
        load_done[i] <= ~wr_meas;
      end else if (accept[i]) begin
        meas_done[i] <= 1'b0;
        load_done[i] <= 1'b0;
      end
    end

    assign corr_word[i*CW +: CW] = (trial_act && trial_ch == IW'(i)) ? trial_val : held[i];
    assign cal_done[i]           = meas_done[i] | load_done[i];

    // R1/R10: disable zeroes word and flags
    a_r10_dis_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en[i] |=> (held[i] == '0 && !meas_done[i] && !load_done[i]));
    // R6: mode flags are exclusive
    a_r6_flag_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(meas_done[i] && load_done[i]));
    // R7: an accepted trigger leaves both flags clear
    a_r7_trig_clears: assert property (@(posedge clk) disable iff (!rst_n)
      accept[i] |=> (!meas_done[i] && !load_done[i]));
    // R8: without a completion write the held word does not move
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en[i] && !wr_oh[i]) |=> $stable(held[i]));
  end
endmodule

// File: rtl/dcoc_ctrl.sv
module dcoc_ctrl #(
  parameter int NCH        = 4,
  parameter int CW         = 8,
  parameter int SETTLE_CYC = 128000,
  parameter int LOAD_CYC   = 24000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    trig_meas,
  input  logic [NCH-1:0]    trig_load,
  input  logic [NCH-1:0]    cmp_above,
  input  logic [NCH*CW-1:0] store_word,
  output logic [NCH*CW-1:0] corr_word,
  output logic [NCH-1:0]    meas_done,
  output logic [NCH-1:0]    load_done,
  output logic [NCH-1:0]    cal_done
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] pend_meas, pend_load, accept, busy_oh, take_oh, wr_oh;
  logic           req_valid, trial_act, wr_meas;
  logic [IW-1:0]  req_idx, trial_ch;
  logic [CW-1:0]  trial_val, wr_val;

  dcoc_trig_queue #(.NCH(NCH)) u_queue (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .trig_meas(trig_meas), .trig_load(trig_load),
    .busy_oh(busy_oh), .take_oh(take_oh),
    .pend_meas(pend_meas), .pend_load(pend_load), .accept(accept)
  );

  dcoc_arbiter #(.NCH(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req((pend_meas | pend_load) & chan_en),
    .req_valid(req_valid), .req_idx(req_idx)
  );

  dcoc_engine #(.NCH(NCH), .CW(CW), .SETTLE_CYC(SETTLE_CYC), .LOAD_CYC(LOAD_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .req_valid(req_valid), .req_idx(req_idx), .pend_meas(pend_meas),
    .cmp_above(cmp_above), .store_word(store_word),
    .busy_oh(busy_oh), .take_oh(take_oh),
    .trial_act(trial_act), .trial_ch(trial_ch), .trial_val(trial_val),
    .wr_oh(wr_oh), .wr_meas(wr_meas), .wr_val(wr_val)
  );

  dcoc_chan_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .accept(accept),
    .wr_oh(wr_oh), .wr_meas(wr_meas), .wr_val(wr_val),
    .trial_act(trial_act), .trial_ch(trial_ch), .trial_val(trial_val),
    .corr_word(corr_word), .meas_done(meas_done),
    .load_done(load_done), .cal_done(cal_done)
  );
endmodule

// File: tb/dcoc_ctrl_bench.sv
module dcoc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int SETTLE = 4;
  localparam int LOADC  = 3;
  localparam int MEAS_LAT = 1 + CW * SETTLE;
  localparam int LOAD_LAT = 1 + LOADC;

  typedef struct packed {
    logic [1:0]        ch;
    logic              is_meas;
    logic signed [7:0] val;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd0, 1'b1, 8'sd0},
    '{2'd1, 1'b1, -8'sd128},
    '{2'd2, 1'b1, 8'sd127},
    '{2'd3, 1'b1, -8'sd1},
    '{2'd0, 1'b1, 8'sd55},
    '{2'd1, 1'b1, -8'sd77},
    '{2'd2, 1'b0, 8'sh5A},
    '{2'd3, 1'b0, -8'sd127},
    '{2'd0, 1'b0, -8'sd128},
    '{2'd1, 1'b1, 8'sd1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    chan_en = '0, trig_meas = '0, trig_load = '0, cmp_above;
  logic [NCH*CW-1:0] store_word = '0;
  logic [NCH*CW-1:0] corr_word;
  logic [NCH-1:0]    meas_done, load_done, cal_done;
  logic signed [7:0] target [NCH];

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_comb
    for (int i = 0; i < NCH; i++)
      cmp_above[i] = $signed(corr_word[i*CW +: CW]) > target[i];

  dcoc_ctrl #(.NCH(NCH), .CW(CW), .SETTLE_CYC(SETTLE), .LOAD_CYC(LOADC)) u_dcoc_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_meas(trig_meas),
    .trig_load(trig_load), .cmp_above(cmp_above), .store_word(store_word),
    .corr_word(corr_word), .meas_done(meas_done), .load_done(load_done),
    .cal_done(cal_done)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int corr(int ch);
    return int'($signed(corr_word[ch*CW +: CW]));
  endfunction

  task automatic pulse(int ch, bit meas, bit load);
    trig_meas[ch] = meas;
    trig_load[ch] = load;
    tick();
    trig_meas = '0;
    trig_load = '0;
  endtask

  task automatic wait_flag(int ch, bit meas, output int n);
    n = 0;
    while (((meas ? meas_done[ch] : load_done[ch]) == 1'b0) && n < 400) begin
      tick();
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < NCH; i++) target[i] = 8'sd0;
    @(negedge clk);
    tick();
    rst_n = 1'b1;
    tick();
    // R1: reset state
    for (int i = 0; i < NCH; i++) check("R1 corr after reset", corr(i), 0);
    check("R1 flags after reset", {meas_done, load_done, cal_done}, 0);

    chan_en = '1;
    // Table walk: R3/R4 measured runs, R5 direct loads, R6 combined flag
    foreach (VECS[k]) begin
      int ch;
      ch = int'(VECS[k].ch);
      if (VECS[k].is_meas) target[ch] = VECS[k].val;
      else store_word[ch*CW +: CW] = VECS[k].val;
      pulse(ch, VECS[k].is_meas, !VECS[k].is_meas);
      check("R7 flags cleared by trigger", cal_done[ch], 0);
      wait_flag(ch, VECS[k].is_meas, n);
      if (VECS[k].is_meas) begin
        check("R4 measured latency", n, MEAS_LAT);
        check("R3 search result", corr(ch), int'(VECS[k].val));
        check("R6 other flag clear", load_done[ch], 0);
      end else begin
        check("R5 load latency", n, LOAD_LAT);
        check("R5 loaded word", corr(ch), int'(VECS[k].val));
        check("R6 other flag clear", meas_done[ch], 0);
      end
      check("R6 combined flag", cal_done[ch], 1);
    end

    // R7: trigger on ch0 leaves other channels' flags alone
    pulse(0, 1'b0, 1'b1);
    check("R7 own flags clear", {meas_done[0], load_done[0]}, 0);
    check("R7 others kept", cal_done[3:1], 3'b111);
    wait_flag(0, 1'b0, n);

    // R8: word held after stored value and comparator change
    store_word[2*CW +: CW] = 8'h11;
    target[2] = -8'sd100;
    repeat (20) tick();
    check("R8 word held", corr(2), 32'sh5A);

    // R3: trial word visible during a run (first trial is 0)
    target[3] = 8'sd40;
    pulse(3, 1'b1, 1'b0);
    tick();
    check("R3 first trial word", corr(3), 0);
    wait_flag(3, 1'b1, n);

    // R9: simultaneous triggers on 3,1,0 complete as 0,1,3
    begin
      int order [3];
      int got;
      logic [NCH-1:0] prev;
      target[0] = 8'sd9; target[1] = -8'sd9; target[3] = 8'sd100;
      trig_meas = 4'b1011;
      tick();
      trig_meas = '0;
      prev = meas_done;
      got = 0;
      for (int c = 0; c < 300 && got < 3; c++) begin
        tick();
        for (int i = 0; i < NCH; i++)
          if (meas_done[i] && !prev[i] && got < 3) begin
            order[got] = i;
            got++;
          end
        prev = meas_done;
      end
      check("R9 first served", order[0], 0);
      check("R9 second served", order[1], 1);
      check("R9 third served", order[2], 3);
      check("R3 ch3 result", corr(3), 100);
    end

    // R10: disable during run aborts, pending ch2 load then runs
    store_word[2*CW +: CW] = 8'h33;
    target[0] = -8'sd50;
    trig_meas[0] = 1'b1;
    trig_load[2] = 1'b1;
    tick();
    trig_meas = '0;
    trig_load = '0;
    repeat (10) tick();
    chan_en[0] = 1'b0;
    tick();
    check("R10 word zeroed", corr(0), 0);
    check("R10 flags cleared", {meas_done[0], load_done[0]}, 0);
    wait_flag(2, 1'b0, n);
    check("R10 next channel served", corr(2), 32'sh33);
    chan_en[0] = 1'b1;

    // R11: trigger on channel being served is ignored
    target[1] = 8'sd21;
    store_word[1*CW +: CW] = 8'h44;
    pulse(1, 1'b1, 1'b0);
    repeat (5) tick();
    pulse(1, 1'b0, 1'b1);
    wait_flag(1, 1'b1, n);
    repeat (15) tick();
    check("R11 busy trigger ignored", load_done[1], 0);
    check("R11 result from run", corr(1), 21);

    // R12: both triggers together take the measured run
    target[2] = -8'sd6;
    pulse(2, 1'b1, 1'b1);
    wait_flag(2, 1'b1, n);
    check("R12 measured chosen", corr(2), -6);
    check("R12 load flag clear", load_done[2], 0);

    // R2: disabled channel ignores triggers
    chan_en[3] = 1'b0;
    store_word[3*CW +: CW] = 8'h70;
    tick();
    pulse(3, 1'b0, 1'b1);
    pulse(3, 1'b1, 1'b0);
    repeat (50) tick();
    check("R2 disabled word", corr(3), 0);
    check("R2 disabled flags", {meas_done[3], load_done[3]}, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule